// File: doc/BRIEF.md
# Hobby Servo Position Pulse Generator

This block drives the control wire of a hobby servo actuator. Every frame of 20 ms it sends one high pulse whose length encodes the commanded shaft angle. The angle arrives as an 8-bit number of degrees. The timebase is a 1 MHz tick that a clock divider elsewhere provides, so every width and period is counted in microseconds and not in system clocks.

The mapping is linear. A 0-degree command gives 388 us, 90 degrees (neutral) gives 1264 us, and 180 degrees gives 2140 us. The general width is 388 + floor(angle * 1752 / 180) us. Commands above 180 saturate at 180.

The block samples the command only on the tick that opens a frame. A pulse that is already running is therefore never cut short or lengthened.

The control lives in a three-state machine:

- ARM is the state after reset, with the output low.
- PULSE is the state with the output high.
- GAP is the state with the output low for the rest of the frame.

The transitions are:

- ARM to PULSE on the first frame-opening tick after reset.
- PULSE to GAP on the tick whose in-frame index equals the width.
- GAP to PULSE on the next frame-opening tick.

Before any frame has started, the command register holds the neutral angle.

Top module: `servo_pulse_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first tick arrives, the output is low.
- R2: Successive rising edges of the output are exactly FRAME_US ticks apart (20000 by default).
- R3: The output rises on the clock cycle after a frame-opening tick. The first tick after reset opens a frame, and every FRAME_US-th tick after it opens the next.
- R4: For an angle A from 0 to 180, the output stays high for exactly 388 + floor(A * 1752 / 180) ticks. For example, A=1 gives 397, A=45 gives 826 and A=179 gives 2130.
- R5: The endpoint and neutral widths are 388 ticks for 0, 1264 ticks for 90 and 2140 ticks for 180.
- R6: Any angle from 181 to 255 produces the same 2140-tick width as 180, and no pulse is ever longer than 2140 ticks.
- R7: The angle is sampled only on the frame-opening tick. A change while a pulse is high does not alter that pulse, and it takes effect in the next frame.
- R8: The output changes only on the clock cycle after a tick. When ticks stop, the output holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle strobe at 1 MHz, the microsecond timebase |
| angle_deg | input | 8 | Commanded angle in degrees, unsigned |
| servo_pwm | output | 1 | Control pulse train to the servo |

## Verification
The angle is swept through both endpoints, neutral, one degree above zero, one degree below full scale and an odd mid value. These separate a wrong offset, a wrong slope and a rounding error in the linear map. Angles of 200 and 255 show whether saturation is applied, which a map that wraps or overflows would fail. A change made while a pulse is high shows whether sampling is confined to the frame start. Running with a tick on only every third clock, and with ticks paused mid-pulse, separates counting of ticks from counting of clocks.

// File: rtl/servo_pkg.sv
package servo_pkg;

    typedef enum logic [1:0] {
        SV_ARM   = 2'd0,
        SV_PULSE = 2'd1,
        SV_GAP   = 2'd2
    } servo_state_e;

endpackage

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
    parameter int FRAME_US = 20000,
    parameter int CNT_W    = $clog2(FRAME_US)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] pos,
    output logic             frame_go
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_US - 1);

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (tick) begin
            if (pos_q == LAST_POS) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign pos      = pos_q;
    assign frame_go = tick && (pos_q == '0);

endmodule

// File: rtl/servo_cmd_latch.sv
module servo_cmd_latch #(
    parameter int ANGLE_W       = 8,
    parameter int MAX_ANGLE     = 180,
    parameter int NEUTRAL_ANGLE = 90
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_go,
    input  logic [ANGLE_W-1:0] angle_in,
    output logic [ANGLE_W-1:0] angle_q
);

    localparam logic [ANGLE_W-1:0] SAT_ANGLE = ANGLE_W'(MAX_ANGLE);
    localparam logic [ANGLE_W-1:0] RST_ANGLE = ANGLE_W'(NEUTRAL_ANGLE);

    logic [ANGLE_W-1:0] angle_sat;

    always_comb begin
        if (angle_in > SAT_ANGLE) begin
            angle_sat = SAT_ANGLE;
        end else begin
            angle_sat = angle_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            angle_q <= RST_ANGLE;
        end else if (frame_go) begin
            angle_q <= angle_sat;
        end
    end

endmodule

// File: rtl/servo_width_map.sv
module servo_width_map #(
    parameter int ANGLE_W   = 8,
    parameter int MIN_US    = 388,
    parameter int SPAN_US   = 1752,
    parameter int MAX_ANGLE = 180,
    parameter int WID_W     = $clog2(MIN_US + SPAN_US + 1)
) (
    input  logic [ANGLE_W-1:0] angle,
    output logic [WID_W-1:0]   width
);

    localparam int PROD_W = ANGLE_W + $clog2(SPAN_US + 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;

    always_comb begin
        prod  = PROD_W'(angle) * PROD_W'(SPAN_US);
        quo   = prod / PROD_W'(MAX_ANGLE);
        width = WID_W'(MIN_US) + WID_W'(quo);
    end

endmodule

// File: rtl/servo_pulse_fsm.sv
module servo_pulse_fsm
    import servo_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int WID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             frame_go,
    input  logic [CNT_W-1:0] pos,
    input  logic [WID_W-1:0] width,
    output logic             pulse
);

    localparam int CMP_W = (CNT_W > WID_W) ? CNT_W : WID_W;

    servo_state_e state_q;
    servo_state_e state_d;
    logic         width_hit;
    logic         pulse_q;

    assign width_hit = tick && (CMP_W'(pos) == CMP_W'(width));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_ARM: begin
                if (frame_go) state_d = SV_PULSE;
            end
            SV_PULSE: begin
                if (width_hit) state_d = SV_GAP;
            end
            SV_GAP: begin
                if (frame_go) state_d = SV_PULSE;
            end
            default: state_d = SV_ARM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SV_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (state_d == SV_PULSE);
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen #(
    parameter int FRAME_US      = 20000,
    parameter int MIN_US        = 388,
    parameter int SPAN_US       = 1752,
    parameter int MAX_ANGLE     = 180,
    parameter int NEUTRAL_ANGLE = 90,
    parameter int ANGLE_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic [ANGLE_W-1:0] angle_deg,
    output logic               servo_pwm
);

    localparam int CNT_W = $clog2(FRAME_US);
    localparam int WID_W = $clog2(MIN_US + SPAN_US + 1);

    logic [CNT_W-1:0]   frame_pos;
    logic               frame_go;
    logic [ANGLE_W-1:0] angle_q;
    logic [WID_W-1:0]   width_us;

    servo_frame_timer #(
        .FRAME_US (FRAME_US),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .pos      (frame_pos),
        .frame_go (frame_go)
    );

    servo_cmd_latch #(
        .ANGLE_W       (ANGLE_W),
        .MAX_ANGLE     (MAX_ANGLE),
        .NEUTRAL_ANGLE (NEUTRAL_ANGLE)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_go (frame_go),
        .angle_in (angle_deg),
        .angle_q  (angle_q)
    );

    servo_width_map #(
        .ANGLE_W   (ANGLE_W),
        .MIN_US    (MIN_US),
        .SPAN_US   (SPAN_US),
        .MAX_ANGLE (MAX_ANGLE),
        .WID_W     (WID_W)
    ) u_map (
        .angle (angle_q),
        .width (width_us)
    );

    servo_pulse_fsm #(
        .CNT_W (CNT_W),
        .WID_W (WID_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .frame_go (frame_go),
        .pos      (frame_pos),
        .width    (width_us),
        .pulse    (servo_pwm)
    );

endmodule

// File: rtl/servo_pulse_chk.sv
module servo_pulse_chk #(
    parameter int MIN_US  = 388,
    parameter int SPAN_US = 1752
) (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic servo_pwm
);

    localparam int HI_W = $clog2(MIN_US + SPAN_US + 2);

    logic [HI_W-1:0] hi_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_ticks <= '0;
        end else if (!servo_pwm) begin
            hi_ticks <= '0;
        end else if (tick_us) begin
            hi_ticks <= hi_ticks + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (servo_pwm == 1'b0); // R1
        end
    end

    AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(servo_pwm) |-> $past(tick_us)); // R3

    AST_FALL_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(servo_pwm) |-> $past(tick_us)); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_us |=> $stable(servo_pwm)); // R8

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(servo_pwm) |-> (hi_ticks >= HI_W'(MIN_US))); // R4

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_pwm && tick_us) |-> (hi_ticks < HI_W'(MIN_US + SPAN_US))); // R6

endmodule

bind servo_pulse_gen servo_pulse_chk #(
    .MIN_US  (MIN_US),
    .SPAN_US (SPAN_US)
) u_servo_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .servo_pwm (servo_pwm)
);

// File: tb/servo_pulse_gen_tb.sv
module servo_pulse_gen_tb_top;

    localparam int FRAME = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic [7:0] angle_deg = 8'd0;
    logic       servo_pwm;

    int    checks = 0;
    int    errors = 0;
    int    tick_div = 0;
    bit    done = 1'b0;
    string phase_req = "R3";

    // model state
    int m_started = 0;
    int m_pos = 0;
    int m_wid = 0;
    bit m_exp = 1'b0;

    // monitor state
    int hi_cnt = 0;
    int last_w = 0;
    int falls = 0;
    int rises = 0;
    int tcount = 0;
    int rise_mark = 0;
    int last_per = 0;
    bit prev_pwm = 1'b0;

    always #4 clk = ~clk;

    servo_pulse_gen #(.FRAME_US(FRAME)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .angle_deg (angle_deg),
        .servo_pwm (servo_pwm)
    );

    function automatic int ref_width(input int a);
        int s;
        s = (a > 180) ? 180 : a;
        return 388 + (s * 1752) / 180;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: position within frame counted in ticks
    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0;
            m_exp = 1'b0;
        end else if (tick_us) begin
            if (m_started == 0) begin
                m_started = 1;
                m_pos = 0;
                m_wid = ref_width(int'(angle_deg));
            end else begin
                m_pos++;
                if (m_pos == FRAME) begin
                    m_pos = 0;
                    m_wid = ref_width(int'(angle_deg));
                end
            end
            m_exp = (m_pos < m_wid);
        end
    end

    // pulse measurement in ticks
    always @(posedge clk) begin
        if (rst_n) begin
            if (servo_pwm && !prev_pwm) begin
                rises++;
                if (rises > 1) last_per = tcount - rise_mark;
                rise_mark = tcount;
            end
            if (!servo_pwm && prev_pwm) begin
                last_w = hi_cnt;
                hi_cnt = 0;
                falls++;
            end
            if (servo_pwm && tick_us) hi_cnt++;
            if (tick_us) tcount++;
            prev_pwm = servo_pwm;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) chk(phase_req, int'(servo_pwm), int'(m_exp));
    end

    // tick driver
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (tick_div == 0) begin
                tick_us = 1'b0;
                ph = 0;
            end else begin
                ph++;
                if (ph >= tick_div) begin
                    tick_us = 1'b1;
                    ph = 0;
                end else begin
                    tick_us = 1'b0;
                end
            end
        end
    end

    task automatic wait_fall();
        int f = falls;
        while (falls == f) @(negedge clk);
    endtask

    task automatic wait_rise();
        int r = rises;
        while (rises == r) @(negedge clk);
    endtask

    task automatic run_angle(input int a, input string req);
        angle_deg = 8'(a);
        wait_fall();
        wait_fall();
        chk(req, last_w, ref_width(a));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", int'(servo_pwm), 0);                     // R1 during reset
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R1", int'(servo_pwm), 0);                 // R1 no tick yet
        end
        tick_div = 1;
        wait_fall();
        chk("R5", last_w, 388);                            // R5 zero degrees
        angle_deg = 8'd90;
        wait_fall();
        chk("R5", last_w, 1264);                           // R5 neutral
        chk("R2", last_per, FRAME);                        // R2 period
        run_angle(180, "R5");
        run_angle(200, "R6");
        run_angle(255, "R6");
        chk("R6", last_w, 2140);
        run_angle(1, "R4");
        chk("R4", last_w, 397);
        run_angle(45, "R4");
        chk("R4", last_w, 826);
        run_angle(179, "R4");
        chk("R4", last_w, 2130);
        // R7: a change while high must not alter the running pulse
        phase_req = "R7";
        angle_deg = 8'd0;
        wait_fall();
        wait_rise();
        angle_deg = 8'd180;
        wait_fall();
        chk("R7", last_w, 388);
        wait_fall();
        chk("R7", last_w, 2140);
        // R8: sparse ticks, then paused ticks mid-pulse
        phase_req = "R8";
        tick_div = 3;
        angle_deg = 8'd90;
        wait_fall();
        chk("R8", last_w, 1264);
        chk("R2", last_per, FRAME);
        wait_rise();
        repeat (30) @(negedge clk);
        tick_div = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R8", int'(servo_pwm), 1);
        end
        tick_div = 1;
        wait_fall();
        chk("R8", last_w, 1264);
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule